// File: doc/BRIEF.md
# Temperature Limit Interrupt Mode Logic

This block turns a stream of finished temperature readings into one temperature error bit for a status register. Each reading is an 8-bit signed value in whole degrees Celsius. When a conversion finishes, the reading is compared with a signed hot limit and a signed hysteresis (low) limit. A 2-bit mode select picks one of three ways to turn those comparisons into the error bit.

The three modes are:
- **Repeat mode.** After an over-limit event, the bit sets again on every conversion until a reading falls below hysteresis.
- **Single-shot mode.** After one event, the bit cannot set again until a reading falls below hysteresis.
- **Follow mode.** The bit tracks the hot-limit comparison directly, with no hysteresis.

Reading the status register, or holding the interrupt clear bit, drops the error bit. A new event in the same cycle as a clear takes priority over the clear. Any change of the mode select returns the internal tracking state to armed.

Top module: `temp_alarm_ctrl`

## Requirements
- R1: After reset, `temp_err` is 0 and the internal state is armed. The mode select value taken as current at reset is 01.
- R2: All comparisons are signed 8-bit two's complement. For example, E7h is -25 and 19h is +25. A reading of D8h (-40) does not exceed a hot limit of E7h (-25). A reading of E7h does not exceed a hot limit of 19h.
- R3: Mode select decoding:
  - 00 and 11 both select repeat mode, and behave the same.
  - 01 selects single-shot mode.
  - 10 selects follow mode.
- R4: Single-shot mode (01):
  - When armed, a conversion whose reading exceeds the hot limit sets `temp_err` and disarms the block.
  - `temp_err` stays set until a status read or an interrupt clear.
  - While disarmed, no conversion sets the bit.
  - A conversion whose reading is below the hysteresis limit re-arms the block.
- R5: Repeat mode (00 or 11):
  - A conversion whose reading exceeds the hot limit sets `temp_err` and starts an over-temperature episode.
  - During an episode, every conversion sets the bit again, including one whose reading lies between the two limits.
  - A conversion whose reading is below hysteresis ends the episode without setting the bit.
- R6: Follow mode (10):
  - A conversion whose reading exceeds the hot limit sets `temp_err`.
  - A conversion whose reading does not exceed the hot limit clears it.
  - A status read or an interrupt clear also clears it.
- R7: With no conversion in the cycle, either `stat_rd` or `irq_clr` clears `temp_err` at the next edge. With none of `conv_done`, `stat_rd` or `irq_clr` active, `temp_err` holds its value.
- R8: A conversion that sets the bit wins over a `stat_rd` or `irq_clr` in the same cycle.
- R9: A hot limit of 7Fh never lets a reading set the bit, because no reading can exceed it.
- R10: Any change of `mode_sel` re-arms single-shot mode and ends any repeat-mode episode. A disarmed single-shot block fires again after the mode changes away and back.
- R11: Both boundaries are strict:
  - A reading equal to the hot limit does not exceed it.
  - A reading equal to the hysteresis limit does not count as below it.
- R12: `temp_err` changes only at the clock edge that samples the conversion, read or clear, and is visible from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | One-cycle strobe: `reading` holds a finished conversion |
| reading | input | 8 | Signed temperature reading, whole degrees Celsius |
| hot_lim | input | 8 | Signed hot limit |
| hyst_lim | input | 8 | Signed hysteresis (low) limit |
| mode_sel | input | 2 | Mode select: 00/11 repeat, 01 single-shot, 10 follow |
| stat_rd | input | 1 | One-cycle strobe: status register read |
| irq_clr | input | 1 | Interrupt clear bit (level) |
| temp_err | output | 1 | Temperature error bit to the status register |

## Verification
The bench probes readings exactly equal to each limit, because a design that compared with greater-or-equal would fire on the hot limit or re-arm on the hysteresis limit. It feeds negative readings and limits, so an unsigned comparator would show up as wrong firing around E7h and D8h.

In single-shot and repeat modes, it re-reads after clearing and converts between the limits. A design that mixed up the two modes would refire too early, or fail to refire during a repeat-mode episode.

It also checks three more cases:
- **Same-cycle clear and set.** A design with the wrong priority would lose the event.
- **A mode change while disarmed.** A design without the re-arm would stay silent.
- **A hot limit of 7Fh.** This limit must never fire.

// File: rtl/temp_alarm_pkg.sv
// temp_alarm_pkg
// Shared mode encoding and decode for the temperature limit interrupt logic.
// Assumes the 2-bit select field is used raw by the host.
package temp_alarm_pkg;

    typedef enum logic [1:0] {
        TM_REPEAT = 2'd0,
        TM_ONCE   = 2'd1,
        TM_FOLLOW = 2'd2
    } tmode_e;

    localparam logic [1:0] MODE_SEL_RESET = 2'b01;

    // Map the raw select field onto a mode; 00 and 11 share repeat mode.
    function automatic tmode_e decode_mode(input logic [1:0] sel);
        tmode_e m;
        case (sel)
            2'b01:   m = TM_ONCE;
            2'b10:   m = TM_FOLLOW;
            default: m = TM_REPEAT;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/temp_cmp.sv
// temp_cmp
// Signed comparison of a reading against the hot and hysteresis limits.
// Assumes all three operands are W-bit two's complement; both tests are strict.
module temp_cmp #(
    parameter int W = 8
) (
    input  logic [W-1:0] reading,
    input  logic [W-1:0] hot_lim,
    input  logic [W-1:0] hyst_lim,
    output logic         over_hot,
    output logic         under_hyst
);

    logic signed [W-1:0] rd_s;
    logic signed [W-1:0] hot_s;
    logic signed [W-1:0] hys_s;

    // Reinterpret operands as signed values.
    always_comb begin
        rd_s  = $signed(reading);
        hot_s = $signed(hot_lim);
        hys_s = $signed(hyst_lim);
    end

    // Strict greater-than against hot, strict less-than against hysteresis.
    always_comb begin
        over_hot   = (rd_s > hot_s);
        under_hyst = (rd_s < hys_s);
    end

endmodule

// File: rtl/temp_mode_fsm.sv
// temp_mode_fsm
// Holds the arm state (single-shot mode) and episode state (repeat mode).
// Turns each conversion into a set request (fire) or a follow-mode drop.
// State moves only on conv_done; any change of mode_sel returns it to armed,
// with no episode open. A conversion in the same cycle as a mode change is
// judged against that fresh state.
module temp_mode_fsm
    import temp_alarm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       conv_done,
    input  logic [1:0] mode_sel,
    input  logic       over_hot,
    input  logic       under_hyst,
    output logic       fire,
    output logic       drop
);

    logic [1:0] mode_q;
    logic       armed_q;
    logic       episode_q;
    logic       mode_chg;
    logic       armed_eff;
    logic       episode_eff;
    logic       armed_d;
    logic       episode_d;
    tmode_e     mode;

    // Decode the mode and detect a select change.
    always_comb begin
        mode        = decode_mode(mode_sel);
        mode_chg    = (mode_sel != mode_q);
        armed_eff   = mode_chg ? 1'b1 : armed_q;
        episode_eff = mode_chg ? 1'b0 : episode_q;
    end

    // Per-mode decision for this conversion.
    always_comb begin
        fire = 1'b0;
        drop = 1'b0;
        if (conv_done) begin
            case (mode)
                TM_ONCE:   fire = armed_eff && over_hot;
                TM_FOLLOW: begin
                    fire = over_hot;
                    drop = !over_hot;
                end
                default:   fire = over_hot || (episode_eff && !under_hyst);
            endcase
        end
    end

    // Next arm and episode state.
    always_comb begin
        armed_d   = armed_eff;
        episode_d = episode_eff;
        if (conv_done) begin
            if (over_hot)
                episode_d = 1'b1;
            else if (under_hyst)
                episode_d = 1'b0;
            if (mode == TM_ONCE) begin
                if (armed_eff && over_hot)
                    armed_d = 1'b0;
                else if (!armed_eff && under_hyst)
                    armed_d = 1'b1;
            end
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= MODE_SEL_RESET;
            armed_q   <= 1'b1;
            episode_q <= 1'b0;
        end else begin
            mode_q    <= mode_sel;
            armed_q   <= armed_d;
            episode_q <= episode_d;
        end
    end

endmodule

// File: rtl/temp_err_flag.sv
// temp_err_flag
// The error bit itself: set by fire; cleared by drop, read or clear.
// Assumes fire has priority over every clearing source in the same cycle.
module temp_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic drop,
    input  logic stat_rd,
    input  logic irq_clr,
    output logic err
);

    logic clear_req;

    // Gather every clearing source.
    always_comb clear_req = drop || stat_rd || irq_clr;

    // Error bit register: set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (fire)
            err <= 1'b1;
        else if (clear_req)
            err <= 1'b0;
    end

endmodule

// File: rtl/temp_alarm_ctrl.sv
// temp_alarm_ctrl
// Top: compares finished temperature readings with signed limits and drives
// the temperature error status bit under the selected interrupt mode.
// Assumes conv_done and stat_rd are single-cycle strobes. Conversion and
// register storage live outside this block.
module temp_alarm_ctrl #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         conv_done,
    input  logic [W-1:0] reading,
    input  logic [W-1:0] hot_lim,
    input  logic [W-1:0] hyst_lim,
    input  logic [1:0]   mode_sel,
    input  logic         stat_rd,
    input  logic         irq_clr,
    output logic         temp_err
);

    logic over_hot;
    logic under_hyst;
    logic fire;
    logic drop;

    temp_cmp #(.W(W)) u_cmp (
        .reading    (reading),
        .hot_lim    (hot_lim),
        .hyst_lim   (hyst_lim),
        .over_hot   (over_hot),
        .under_hyst (under_hyst)
    );

    temp_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_done  (conv_done),
        .mode_sel   (mode_sel),
        .over_hot   (over_hot),
        .under_hyst (under_hyst),
        .fire       (fire),
        .drop       (drop)
    );

    temp_err_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .drop    (drop),
        .stat_rd (stat_rd),
        .irq_clr (irq_clr),
        .err     (temp_err)
    );

endmodule

// File: rtl/temp_alarm_chk.sv
// temp_alarm_chk
// Port-level checker for temp_alarm_ctrl, attached with bind below.
module temp_alarm_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         conv_done,
    input logic [W-1:0] reading,
    input logic [W-1:0] hot_lim,
    input logic [W-1:0] hyst_lim,
    input logic [1:0]   mode_sel,
    input logic         stat_rd,
    input logic         irq_clr,
    input logic         temp_err
);

    localparam logic [W-1:0] MAX_POS = {1'b0, {(W-1){1'b1}}};

    logic above;
    logic hyst_low;

    // Independent signed view of the limit test.
    always_comb begin
        above    = $signed(reading) > $signed(hot_lim);
        hyst_low = $signed(hyst_lim) < $signed(hot_lim);
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !temp_err);

    assert_follow_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && mode_sel == 2'b10 && above |=> temp_err);

    assert_follow_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && mode_sel == 2'b10 && !above |=> !temp_err);

    assert_clear_no_conv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done && (stat_rd || irq_clr) |=> !temp_err);

    assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done && !stat_rd && !irq_clr |=> $stable(temp_err));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done && above && (mode_sel == 2'b00 || mode_sel == 2'b11) && (stat_rd || irq_clr)
        |=> temp_err);

    assert_max_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !temp_err && hot_lim == MAX_POS && hyst_low && (mode_sel == 2'b01 || mode_sel == 2'b10)
        |=> !temp_err);

    assert_rise_needs_conv_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(temp_err) |-> $past(conv_done));

endmodule

bind temp_alarm_ctrl temp_alarm_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_done (conv_done),
    .reading   (reading),
    .hot_lim   (hot_lim),
    .hyst_lim  (hyst_lim),
    .mode_sel  (mode_sel),
    .stat_rd   (stat_rd),
    .irq_clr   (irq_clr),
    .temp_err  (temp_err)
);

// File: tb/tb_temp_alarm_ctrl.sv
module tb_temp_alarm_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       conv_done = 1'b0;
    logic [7:0] reading = 8'h00;
    logic [7:0] hot_lim = 8'h19;
    logic [7:0] hyst_lim = 8'h14;
    logic [1:0] mode_sel = 2'b01;
    logic       stat_rd = 1'b0;
    logic       irq_clr = 1'b0;
    logic       temp_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    temp_alarm_ctrl dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .conv_done (conv_done),
        .reading   (reading),
        .hot_lim   (hot_lim),
        .hyst_lim  (hyst_lim),
        .mode_sel  (mode_sel),
        .stat_rd   (stat_rd),
        .irq_clr   (irq_clr),
        .temp_err  (temp_err)
    );

    task automatic check(input string req, input string what, input logic exp);
        total++;
        if (temp_err !== exp) begin
            bad++;
            $display("FAIL %s %s: temp_err=%b expected=%b", req, what, temp_err, exp);
        end
    endtask

    // One cycle of stimulus; returns at the following falling edge.
    task automatic cycle(input logic c, input logic [7:0] r, input logic rd, input logic clr);
        @(negedge clk);
        conv_done = c;
        reading   = r;
        stat_rd   = rd;
        irq_clr   = clr;
        @(negedge clk);
        conv_done = 1'b0;
        stat_rd   = 1'b0;
        irq_clr   = 1'b0;
    endtask

    task automatic conv(input logic [7:0] r);
        cycle(1'b1, r, 1'b0, 1'b0);
    endtask

    task automatic rd();
        cycle(1'b0, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic set_mode(input logic [1:0] m);
        @(negedge clk);
        mode_sel = m;
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1", "after reset", 1'b0);
    endtask

    task automatic t_once();
        conv(8'h1E); check("R4", "once fires above hot", 1'b1);
        rd();        check("R7", "read clears", 1'b0);
        conv(8'h1E); check("R4", "disarmed no refire", 1'b0);
        conv(8'h16); check("R4", "between limits no fire", 1'b0);
        conv(8'h14); conv(8'h1E); check("R11", "equal hyst does not rearm", 1'b0);
        conv(8'h13); check("R4", "rearm conversion no set", 1'b0);
        conv(8'h1E); check("R4", "fires after rearm", 1'b1);
        rd();
    endtask

    task automatic t_repeat();
        set_mode(2'b00);
        conv(8'h1E); check("R5", "repeat fires", 1'b1);
        rd();
        conv(8'h16); check("R5", "refire between limits", 1'b1);
        rd();
        conv(8'h13); check("R5", "below hyst ends episode", 1'b0);
        conv(8'h16); check("R5", "no fire after episode end", 1'b0);
        conv(8'h19); check("R11", "equal hot does not fire", 1'b0);
        conv(8'h1A); check("R11", "one above hot fires", 1'b1);
        rd();
        set_mode(2'b11);
        conv(8'h1E); check("R3", "select 11 fires", 1'b1);
        rd();
        conv(8'h16); check("R3", "select 11 repeats like 00", 1'b1);
        rd();
    endtask

    task automatic t_follow();
        set_mode(2'b10);
        conv(8'h1E); check("R6", "follow sets", 1'b1);
        conv(8'h19); check("R6", "follow drops at hot", 1'b0);
        conv(8'h1E);
        rd();        check("R6", "read clears follow", 1'b0);
        cycle(1'b1, 8'h1E, 1'b1, 1'b0); check("R8", "set wins over read", 1'b1);
        cycle(1'b1, 8'h1E, 1'b0, 1'b1); check("R8", "set wins over clear", 1'b1);
        cycle(1'b0, 8'h00, 1'b0, 1'b1); check("R7", "irq_clr clears", 1'b0);
        conv(8'h1E);
        cycle(1'b0, 8'h00, 1'b0, 1'b0);
        cycle(1'b0, 8'h00, 1'b0, 1'b0); check("R7", "idle holds set", 1'b1);
        cycle(1'b0, 8'h00, 1'b0, 1'b1);
        cycle(1'b0, 8'h00, 1'b0, 1'b0); check("R7", "idle holds clear", 1'b0);
    endtask

    task automatic t_signed();
        hot_lim = 8'hE7; hyst_lim = 8'hD0;
        conv(8'hD8); check("R2", "-40 not above -25", 1'b0);
        conv(8'h19); check("R2", "+25 above -25", 1'b1);
        hot_lim = 8'h19; hyst_lim = 8'h14;
        conv(8'hE7); check("R2", "-25 not above +25", 1'b0);
    endtask

    task automatic t_maxlim();
        hot_lim = 8'h7F;
        set_mode(2'b00);
        conv(8'h7F); check("R9", "7F limit repeat", 1'b0);
        conv(8'h7E); check("R9", "7F limit repeat below", 1'b0);
        set_mode(2'b01);
        conv(8'h7F); check("R9", "7F limit once", 1'b0);
        hot_lim = 8'h19;
    endtask

    task automatic t_modechg();
        conv(8'h1E); check("R10", "once fires", 1'b1);
        rd();
        conv(8'h1E); check("R10", "disarmed", 1'b0);
        set_mode(2'b10);
        set_mode(2'b01);
        conv(8'h1E); check("R10", "mode change rearms", 1'b1);
        rd();
    endtask

    initial begin
        #50000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: run hung");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_once();
        t_repeat();
        t_follow();
        t_signed();
        t_maxlim();
        t_modechg();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule